// File: doc/BRIEF.md
# Temperature-Proportional Fan PWM Generator

This block drives a brushless DC fan with a fixed-rate pulse-width signal. Each frame is split into `STEPS` equal duty slots. The duty of a frame is the number of leading slots in which the drive output is high. The clock divider is `STEPS * SLOT_CLKS` system clocks per frame, and these two parameters set the frame rate (nominally about 30 Hz in a real system).

The duty can come from two places. One is a digitized temperature code, mapped linearly from a 30 % floor up to 100 % between two parameterized code points. The other is a duty value written by a host, selected by a mode input. If the temperature sensor is flagged as absent while sensor mode is active, a fixed fallback duty of about 39.33 % applies. All duties are clamped between the 30 % floor and 100 %.

A new duty is taken only at a frame boundary, so a frame is never cut short or stretched. A shutdown input stops the drive at once. When shutdown is released, a fresh frame starts.

Top module: `fan_pwm_drive`

## Requirements
- R1: A running frame lasts `STEPS*SLOT_CLKS` clock cycles. The output `drive_o` is high for the first `D*SLOT_CLKS` cycles of the frame and low for the rest, where D is the duty of that frame in steps (0..STEPS, and STEPS means 100 %).
- R2: In sensor mode (`mode_host_i`=0, `temp_ok_i`=1), D is computed from the temperature code t as follows, with FLOOR = floor(STEPS*3/10):
  - D = FLOOR when t <= TEMP_LO.
  - D = STEPS when t >= TEMP_HI.
  - Otherwise D = FLOOR + floor((t-TEMP_LO)*(STEPS-FLOOR)/(TEMP_HI-TEMP_LO)).
  - With the defaults (STEPS=100, TEMP_LO=503, TEMP_HI=807) this is D = 30 + floor((t-503)*70/304).
- R3: In sensor mode with `temp_ok_i`=0, D is the fallback round(STEPS*0.3933), which is 39 with the defaults. The temperature code has no effect.
- R4: In host mode (`mode_host_i`=1), D is `host_duty_i` clamped to the range [FLOOR, STEPS]. Both `temp_ok_i` and `temp_code_i` have no effect in this mode.
- R5: At D = STEPS the output stays high for the whole frame, with no low cycle between consecutive full-duty frames.
- R6: A change of any duty-selecting input during a frame does not alter that frame. The change takes effect from the next frame on.
- R7: While `shutdown_i` is high, `drive_o` is low from the cycle after it is seen. On release, a new frame begins at the next clock edge using the inputs present at that edge.
- R8: `drive_o` is low during reset (`rst_i`=1, synchronous, active high) and in the cycle in which reset is released. The first frame starts at the first clock edge with reset low.
- R9: If shutdown is asserted in the last cycle of a frame, shutdown takes priority over the frame reload, and the output is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| temp_code_i | input | TEMP_W | Digitized temperature code |
| temp_ok_i | input | 1 | Temperature code is valid (sensor present) |
| host_duty_i | input | DUTY_W | Host-written duty in steps |
| mode_host_i | input | 1 | 1 selects the host duty, 0 selects the sensor |
| shutdown_i | input | 1 | Forces the drive low and stops the frame timer |
| drive_o | output | 1 | Active-high fan drive |

## Verification
Two events can fall in the same clock edge: the frame-boundary reload of the duty, and a shutdown request. They meet when shutdown is raised exactly in the last cycle of a frame while the selected duty has just been changed to 100 %. The bench requires the output to go low at that edge rather than start a full-duty frame, and then requires the frame that follows the release to carry the new duty. The same collision with an input change is covered by changing the duty selection in the middle of every frame. Each frame is then compared cycle by cycle against the duty that was selected before the change.

// File: rtl/fanpwm_pkg.sv
package fanpwm_pkg;

    localparam int RAW_W = 16;

    typedef enum logic [1:0] {
        SRC_SENSOR  = 2'd0,
        SRC_DEFAULT = 2'd1,
        SRC_HOST    = 2'd2
    } duty_src_e;

    typedef struct packed {
        duty_src_e          src;
        logic [RAW_W-1:0]   raw;
    } duty_req_t;

    // Lowest allowed duty: 30 percent of the frame, in steps.
    function automatic int floor_steps(input int steps);
        return (steps * 3) / 10;
    endfunction

    // Fallback duty for a missing sensor: 39.33 percent, rounded.
    function automatic int default_steps(input int steps);
        return (steps * 3933 + 5000) / 10000;
    endfunction

    // Linear temperature-to-duty map between the floor and full duty.
    function automatic int map_temp(input int code, input int lo,
                                    input int hi, input int steps);
        int fl;
        fl = floor_steps(steps);
        if (code <= lo)
            return fl;
        else if (code >= hi)
            return steps;
        else
            return fl + ((code - lo) * (steps - fl)) / (hi - lo);
    endfunction

endpackage

// File: rtl/fan_duty_select.sv
module fan_duty_select
    import fanpwm_pkg::*;
#(
    parameter int STEPS   = 100,
    parameter int TEMP_W  = 10,
    parameter int TEMP_LO = 503,
    parameter int TEMP_HI = 807,
    parameter int DUTY_W  = 7
) (
    input  logic [TEMP_W-1:0] temp_code_i,
    input  logic              temp_ok_i,
    input  logic [DUTY_W-1:0] host_duty_i,
    input  logic              mode_host_i,
    output duty_req_t         req_o
);

    localparam int DEF_STEPS = default_steps(STEPS);

    always_comb begin
        if (mode_host_i) begin
            req_o.src = SRC_HOST;
            req_o.raw = RAW_W'(host_duty_i);
        end else if (!temp_ok_i) begin
            req_o.src = SRC_DEFAULT;
            req_o.raw = RAW_W'(DEF_STEPS);
        end else begin
            req_o.src = SRC_SENSOR;
            req_o.raw = RAW_W'(map_temp(int'(temp_code_i), TEMP_LO, TEMP_HI, STEPS));
        end
    end

endmodule

// File: rtl/fan_duty_clamp.sv
module fan_duty_clamp
    import fanpwm_pkg::*;
#(
    parameter int STEPS  = 100,
    parameter int DUTY_W = 7
) (
    input  duty_req_t         req_i,
    output logic [DUTY_W-1:0] duty_o
);

    localparam logic [RAW_W-1:0] LOW_LIM  = RAW_W'(floor_steps(STEPS));
    localparam logic [RAW_W-1:0] HIGH_LIM = RAW_W'(STEPS);

    logic [RAW_W-1:0] bounded;

    always_comb begin
        if (req_i.raw < LOW_LIM)
            bounded = LOW_LIM;
        else if (req_i.raw > HIGH_LIM)
            bounded = HIGH_LIM;
        else
            bounded = req_i.raw;
        duty_o = bounded[DUTY_W-1:0];
    end

endmodule

// File: rtl/fan_frame_timer.sv
module fan_frame_timer #(
    parameter int STEPS     = 100,
    parameter int SLOT_CLKS = 4,
    parameter int CNT_W     = 7
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             hold_i,
    output logic [CNT_W-1:0] slot_o,
    output logic             run_o,
    output logic             load_o
);

    logic             run_q;
    logic [CNT_W-1:0] slot_q;
    logic             slot_end;
    logic             frame_last;

    generate
        if (SLOT_CLKS > 1) begin : g_prescale
            localparam int PRE_W = $clog2(SLOT_CLKS);
            logic [PRE_W-1:0] pre_q;

            always_ff @(posedge clk_i) begin
                if (rst_i || hold_i || !run_q)
                    pre_q <= '0;
                else if (pre_q == PRE_W'(SLOT_CLKS - 1))
                    pre_q <= '0;
                else
                    pre_q <= pre_q + 1'b1;
            end

            assign slot_end = (pre_q == PRE_W'(SLOT_CLKS - 1));
        end else begin : g_direct
            assign slot_end = 1'b1;
        end
    endgenerate

    assign frame_last = slot_end && (slot_q == CNT_W'(STEPS - 1));
    assign load_o     = !hold_i && (!run_q || frame_last);

    always_ff @(posedge clk_i) begin
        if (rst_i || hold_i) begin
            run_q  <= 1'b0;
            slot_q <= '0;
        end else begin
            run_q <= 1'b1;
            if (load_o)
                slot_q <= '0;
            else if (slot_end)
                slot_q <= slot_q + 1'b1;
        end
    end

    assign slot_o = slot_q;
    assign run_o  = run_q;

endmodule

// File: rtl/fan_pwm_drive.sv
module fan_pwm_drive
    import fanpwm_pkg::*;
#(
    parameter int  STEPS     = 100,
    parameter int  SLOT_CLKS = 4,
    parameter int  TEMP_W    = 10,
    parameter int  TEMP_LO   = 503,
    parameter int  TEMP_HI   = 807,
    localparam int DUTY_W    = $clog2(STEPS + 1)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [TEMP_W-1:0] temp_code_i,
    input  logic              temp_ok_i,
    input  logic [DUTY_W-1:0] host_duty_i,
    input  logic              mode_host_i,
    input  logic              shutdown_i,
    output logic              drive_o
);

    duty_req_t         req_w;
    logic [DUTY_W-1:0] target_w;
    logic [DUTY_W-1:0] duty_q;
    logic [DUTY_W-1:0] slot_w;
    logic              run_w;
    logic              load_w;

    fan_duty_select #(
        .STEPS   (STEPS),
        .TEMP_W  (TEMP_W),
        .TEMP_LO (TEMP_LO),
        .TEMP_HI (TEMP_HI),
        .DUTY_W  (DUTY_W)
    ) i_select (
        .temp_code_i (temp_code_i),
        .temp_ok_i   (temp_ok_i),
        .host_duty_i (host_duty_i),
        .mode_host_i (mode_host_i),
        .req_o       (req_w)
    );

    fan_duty_clamp #(
        .STEPS  (STEPS),
        .DUTY_W (DUTY_W)
    ) i_clamp (
        .req_i  (req_w),
        .duty_o (target_w)
    );

    fan_frame_timer #(
        .STEPS     (STEPS),
        .SLOT_CLKS (SLOT_CLKS),
        .CNT_W     (DUTY_W)
    ) i_timer (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .hold_i (shutdown_i),
        .slot_o (slot_w),
        .run_o  (run_w),
        .load_o (load_w)
    );

    // Duty is captured only at a frame boundary.
    always_ff @(posedge clk_i) begin
        if (rst_i || shutdown_i)
            duty_q <= '0;
        else if (load_w)
            duty_q <= target_w;
    end

    assign drive_o = run_w && (slot_w < duty_q);

endmodule

// File: rtl/fan_pwm_drive_chk.sv
module fan_pwm_drive_chk #(
    parameter int STEPS  = 100,
    parameter int DUTY_W = 7
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              shutdown_i,
    input logic              drive_o,
    input logic [DUTY_W-1:0] duty_q,
    input logic [DUTY_W-1:0] slot_w,
    input logic              run_w,
    input logic              load_w
);

    localparam logic [DUTY_W-1:0] FLOOR_D = DUTY_W'(fanpwm_pkg::floor_steps(STEPS));
    localparam logic [DUTY_W-1:0] FULL_D  = DUTY_W'(STEPS);

    a_r1_slot_in_frame: assert property (@(posedge clk_i) disable iff (rst_i)
        run_w |-> (slot_w < FULL_D));

    a_r4_duty_in_range: assert property (@(posedge clk_i) disable iff (rst_i)
        run_w |-> (duty_q >= FLOOR_D && duty_q <= FULL_D));

    a_r5_full_stays_high: assert property (@(posedge clk_i) disable iff (rst_i)
        (run_w && duty_q == FULL_D) |-> drive_o);

    a_r6_duty_frame_only: assert property (@(posedge clk_i) disable iff (rst_i)
        (!load_w && !shutdown_i) |=> $stable(duty_q));

    a_r7_shutdown_low: assert property (@(posedge clk_i) disable iff (rst_i)
        shutdown_i |=> !drive_o);

    a_r8_low_at_release: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(rst_i) |-> !drive_o);

endmodule

bind fan_pwm_drive fan_pwm_drive_chk #(
    .STEPS  (STEPS),
    .DUTY_W (DUTY_W)
) i_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .shutdown_i (shutdown_i),
    .drive_o    (drive_o),
    .duty_q     (duty_q),
    .slot_w     (slot_w),
    .run_w      (run_w),
    .load_w     (load_w)
);

// File: tb/test_fan_pwm_drive.sv
module test_fan_pwm_drive;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int STEPS = 100;
    localparam int SC    = 4;
    localparam int FRAME = STEPS * SC;

    logic       clk = 1'b0;
    logic       rst;
    logic [9:0] temp_code;
    logic       temp_ok;
    logic [6:0] host_duty;
    logic       mode_host;
    logic       shutdown;
    logic       drive;

    int checks = 0;
    int errors = 0;
    int prev_exp = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    fan_pwm_drive i_fan_pwm_drive (
        .clk_i       (clk),
        .rst_i       (rst),
        .temp_code_i (temp_code),
        .temp_ok_i   (temp_ok),
        .host_duty_i (host_duty),
        .mode_host_i (mode_host),
        .shutdown_i  (shutdown),
        .drive_o     (drive)
    );

    function automatic int exp_duty(bit h, bit ok, int t, int r);
        if (h) return (r < 30) ? 30 : ((r > 100) ? 100 : r);
        if (!ok) return 39;
        if (t <= 503) return 30;
        if (t >= 807) return 100;
        return 30 + ((t - 503) * 70) / 304;
    endfunction

    task automatic set_in(bit h, bit ok, int t, int r);
        mode_host = h;
        temp_ok   = ok;
        temp_code = 10'(t);
        host_duty = 7'(r);
    endtask

    task automatic check_bit(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: drive actual %b expected %b", tag, act, exp);
        end
    endtask

    // Checks the current frame against prev_exp; switches inputs mid-frame.
    task automatic do_frame(bit h, bit ok, int t, int r, string tag);
        int bad = 0;
        int first = -1;
        logic fv = 1'b0;
        for (int i = 0; i < FRAME; i++) begin
            @(negedge clk);
            if (drive !== (i < prev_exp * SC)) begin
                if (bad == 0) begin first = i; fv = drive; end
                bad++;
            end
            if (i == FRAME / 3) set_in(h, ok, t, r);
        end
        checks++;
        if (bad != 0) begin
            errors++;
            $display("FAIL %s: cycle %0d of frame actual %b expected %b (duty %0d)",
                     tag, first, fv, ~fv, prev_exp);
        end
        prev_exp = exp_duty(h, ok, t, r);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1;
        shutdown = 1'b0;
        set_in(0, 1, 0, 0);
        repeat (3) @(negedge clk);
        check_bit("R8 during reset", drive, 1'b0);
        rst = 1'b0;
        #0.1 check_bit("R8 at release", drive, 1'b0);
        prev_exp = exp_duty(0, 1, 0, 0);

        // Directed patterns; each frame checks the previous selection (R1, R6)
        do_frame(0, 1, 503, 0, "R8 first frame / R2 low point");
        do_frame(0, 1, 807, 0, "R2 low point");
        do_frame(0, 1, 1023, 0, "R2 high point");
        do_frame(0, 1, 655, 0, "R5 full duty consecutive");
        do_frame(0, 0, 900, 0, "R2 midpoint");
        do_frame(1, 0, 900, 0, "R3 sensor absent");
        do_frame(1, 1, 0, 127, "R4 host below floor");
        do_frame(1, 0, 1023, 55, "R4 host above full");
        do_frame(0, 1, 504, 55, "R4 host ignores sensor");
        do_frame(0, 1, 700, 55, "R2 just above low point");

        // R7: shutdown mid-frame, inputs changed while held
        begin
            int bad = 0;
            for (int i = 0; i <= 200; i++) begin
                @(negedge clk);
                if (drive !== (i < prev_exp * SC)) bad++;
            end
            shutdown = 1'b1;
            set_in(0, 1, 807, 0);
            for (int j = 0; j < 50; j++) begin
                @(negedge clk);
                if (drive !== 1'b0) bad++;
            end
            checks++;
            if (bad != 0) begin
                errors++;
                $display("FAIL R7: %0d cycles wrong, actual drive %b expected 0 while held", bad, drive);
            end
            shutdown = 1'b0;
            prev_exp = 100;
        end
        do_frame(0, 1, 560, 0, "R7 restart uses current inputs");

        // R9: shutdown in the last cycle of a frame beats the reload
        begin
            int bad = 0;
            for (int i = 0; i < FRAME; i++) begin
                @(negedge clk);
                if (drive !== (i < prev_exp * SC)) bad++;
                if (i == FRAME / 3) set_in(1, 1, 0, 100);
            end
            checks++;
            if (bad != 0) begin
                errors++;
                $display("FAIL R1: %0d cycles wrong before collision, duty %0d", bad, prev_exp);
            end
            shutdown = 1'b1;
            @(negedge clk);
            check_bit("R9 shutdown wins over reload", drive, 1'b0);
            @(negedge clk);
            check_bit("R7 held low", drive, 1'b0);
            shutdown = 1'b0;
            prev_exp = 100;
        end
        do_frame(1, 1, 0, 40, "R9 frame after release");

        // Random frames
        for (int k = 0; k < 24; k++) begin
            bit h  = 1'($urandom % 2);
            bit ok = (($urandom % 4) != 0);
            int t  = int'($urandom % 1024);
            int r  = int'($urandom % 128);
            do_frame(h, ok, t, r, "R1 random");
        end
        do_frame(0, 1, 0, 0, "R6 random tail");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule